// File: doc/BRIEF.md
# Indirect Management Register Access Engine

This block lets a host reach the 16-bit registers of a multi-device Ethernet switch over a shared management bus. The host gives it one request at a time: a device address, a register address, a direction and, for writes, the data. The block turns the request into a chain of single read/write transactions on a lower management port, which carries no bit-level framing. When the request is done it returns a one-cycle response with the read data and two error flags.

When the configured chip address is non-zero, the switch answers only at that bus address and the block works indirectly. It polls a busy flag in a command register, loads a data register, writes a command word, polls again and, for reads, fetches the data register. When the chip address is zero, the block issues a single direct transaction: the device address goes out as the bus address. Each busy poll is retried after a fixed gap, counted in clock cycles, up to a set number of attempts. A lower-port error ends the chain at once.

Top module: `mgmt_indirect_access`

## Requirements
- R1: With `cfg_chip_addr` equal to 0, a request causes exactly one lower-port transaction. That transaction has the request's direction, `bus_req_phy` equal to the device address and `bus_req_reg` equal to the register address. A read returns `bus_rdata` in `rsp_rdata`.
- R2: With a non-zero chip address, a read issues these transactions in order, all at the chip address: a busy poll (read of offset 0), a command write (offset 0), a second busy poll, then a read of the data register (offset 1). The value of that last read is returned in `rsp_rdata`.
- R3: With a non-zero chip address, a write issues these transactions in order: a busy poll, a write of `req_wdata` to offset 1, a command write to offset 0, then a second busy poll. `rsp_rdata` is 0.
- R4: The command word has bit 15 set (busy) and bit 12 set (clause-22 select). Bits 11:10 hold 2'b10 for a read or 2'b01 for a write. Bits 9:5 hold the device address and bits 4:0 the register address.
- R5: A poll whose returned bit 15 is 1 is repeated, and the lower port sees exactly `POLL_GAP` cycles with no request between the two polls.
- R6: If `MAX_POLLS` consecutive polls in one wait phase all return busy, the response carries `rsp_timeout`=1 and no further transaction is issued. A clear result on the `MAX_POLLS`-th poll lets the sequence go on.
- R7: A transaction acknowledged with `bus_err`=1 ends the request at once: the response carries `rsp_error`=1 and `rsp_rdata`=0, and nothing more is issued. This holds even when the same poll result shows busy clear. `rsp_error` and `rsp_timeout` are never set together.
- R8: `req_ready` is high only while idle. It drops in the cycle after acceptance and stays low until the response cycle has passed.
- R9: `rsp_valid` is a one-cycle pulse per request. On success both error flags are 0.
- R10: After a timeout or an error, the next request is carried out normally.
- R11: Once raised, `bus_req_valid` and all request fields stay stable until the cycle in which `bus_ack` is high.
- R12: After reset `req_ready` is 1, and `bus_req_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_chip_addr | input | 5 | Bus address of the switch; 0 selects direct access |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Target device address inside the switch |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 16 | Read data (0 for writes and failures) |
| rsp_timeout | output | 1 | Busy polling gave up |
| rsp_error | output | 1 | Lower port reported an error |
| bus_req_valid | output | 1 | Lower-port transaction request |
| bus_req_write | output | 1 | Lower-port direction |
| bus_req_phy | output | 5 | Lower-port bus address |
| bus_req_reg | output | 5 | Lower-port register offset |
| bus_req_wdata | output | 16 | Lower-port write data |
| bus_ack | input | 1 | Lower-port completion, one cycle |
| bus_rdata | input | 16 | Lower-port read data, valid with `bus_ack` |
| bus_err | input | 1 | Lower-port error, valid with `bus_ack` |

## Verification
Two outcomes can be decided by the same acknowledge. In the first, the last allowed poll returns either busy or clear, so the attempt limit and the advance to the next step meet on one edge. The bench provokes this with the switch model held busy for exactly `MAX_POLLS` polls and for one fewer, and expects a timeout in the first case and a full sequence in the second. In the second, a lower-port error arrives on a poll whose busy bit is clear. The bench expects the error to win, with no further transaction and no read data. A behavioural model in the bench predicts the exact list of lower-port transactions and the response for each request, and the bench compares against it as each transaction completes.

// File: rtl/mgmt_acc_pkg.sv
// Shared constants, step encoding and command-word builder for the
// indirect management access engine.
package mgmt_acc_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    // Offsets of the indirection register pair inside the switch
    localparam logic [ADDR_W-1:0] CMD_OFS  = 5'd0;
    localparam logic [ADDR_W-1:0] DATA_OFS = 5'd1;

    // Command word field positions
    localparam int BUSY_BIT = 15;
    localparam int C22_BIT  = 12;
    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIRECT,
        ST_POLL,
        ST_GAP,
        ST_WDATA,
        ST_WCMD,
        ST_RDATA,
        ST_RESP
    } step_t;

    // Compose the command word written to the command register
    function automatic logic [DATA_W-1:0] make_cmd(
        input logic              wr,
        input logic [ADDR_W-1:0] dev,
        input logic [ADDR_W-1:0] rg
    );
        logic [DATA_W-1:0] w;
        w           = '0;
        w[BUSY_BIT] = 1'b1;
        w[C22_BIT]  = 1'b1;
        w[11:10]    = wr ? OP_WR : OP_RD;
        w[9:5]      = dev;
        w[4:0]      = rg;
        return w;
    endfunction

endpackage

// File: rtl/mgmt_poll_timer.sv
// Poll pacing for the access engine.
// Counts the idle gap between busy polls and the number of busy polls
// seen in the current wait phase. Assumes clear and busy_seen are never
// high together, and that gap_run is high only while the engine waits.
module mgmt_poll_timer #(
    parameter int POLL_GAP  = 1000,
    parameter int MAX_POLLS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic busy_seen,
    input  logic gap_run,
    output logic gap_done,
    output logic at_limit
);
    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam int ATT_W = $clog2(MAX_POLLS + 1);

    logic [GAP_W-1:0] gap_cnt;
    logic [ATT_W-1:0] att_cnt;

    assign gap_done = gap_run && (gap_cnt == GAP_W'(POLL_GAP - 1));
    assign at_limit = (att_cnt == ATT_W'(MAX_POLLS - 1));

    // Cycle counter for the pause between two polls
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_cnt <= '0;
        else if (gap_run && !gap_done)
            gap_cnt <= gap_cnt + 1'b1;
        else
            gap_cnt <= '0;
    end

    // Busy-poll attempt counter for the current wait phase
    always_ff @(posedge clk) begin
        if (!rst_n)
            att_cnt <= '0;
        else if (clear)
            att_cnt <= '0;
        else if (busy_seen && !at_limit)
            att_cnt <= att_cnt + 1'b1;
    end

    a_r5_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt < GAP_W'(POLL_GAP));

    a_r6_attempts_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        att_cnt < ATT_W'(MAX_POLLS));

endmodule

// File: rtl/mgmt_bus_drive.sv
// Lower-port request decoder.
// Maps the engine's current step and the latched request onto one
// lower-port transaction. Purely combinational; assumes its inputs
// are held stable by the sequencer while a transaction is pending.
module mgmt_bus_drive
    import mgmt_acc_pkg::*;
(
    input  step_t             step,
    input  logic              l_write,
    input  logic [ADDR_W-1:0] l_dev,
    input  logic [ADDR_W-1:0] l_reg,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic [ADDR_W-1:0] l_chip,
    output logic              bus_req_valid,
    output logic              bus_req_write,
    output logic [ADDR_W-1:0] bus_req_phy,
    output logic [ADDR_W-1:0] bus_req_reg,
    output logic [DATA_W-1:0] bus_req_wdata
);
    // Select the transaction fields for each step
    always_comb begin
        bus_req_valid = 1'b0;
        bus_req_write = 1'b0;
        bus_req_phy   = l_chip;
        bus_req_reg   = CMD_OFS;
        bus_req_wdata = '0;
        unique case (step)
            ST_DIRECT: begin
                bus_req_valid = 1'b1;
                bus_req_write = l_write;
                bus_req_phy   = l_dev;
                bus_req_reg   = l_reg;
                bus_req_wdata = l_wdata;
            end
            ST_POLL: begin
                bus_req_valid = 1'b1;
            end
            ST_WDATA: begin
                bus_req_valid = 1'b1;
                bus_req_write = 1'b1;
                bus_req_reg   = DATA_OFS;
                bus_req_wdata = l_wdata;
            end
            ST_WCMD: begin
                bus_req_valid = 1'b1;
                bus_req_write = 1'b1;
                bus_req_wdata = make_cmd(l_write, l_dev, l_reg);
            end
            ST_RDATA: begin
                bus_req_valid = 1'b1;
                bus_req_reg   = DATA_OFS;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mgmt_acc_seq.sv
// Request sequencer for the access engine.
// Accepts one request while idle, latches it together with the chip
// address, and walks the direct or indirect transaction chain. A poll
// result is judged on the acknowledge only. A lower-port error always
// outranks the busy/clear outcome of the same acknowledge.
module mgmt_acc_seq
    import mgmt_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_chip_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_dev,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              gap_done,
    input  logic              at_limit,
    output logic              poll_clear,
    output logic              poll_busy,
    output logic              gap_run,
    output step_t             step,
    output logic              l_write,
    output logic [ADDR_W-1:0] l_dev,
    output logic [ADDR_W-1:0] l_reg,
    output logic [DATA_W-1:0] l_wdata,
    output logic [ADDR_W-1:0] l_chip,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_timeout,
    output logic              rsp_error
);
    step_t             step_q, step_d;
    logic              phase2_q;
    logic              err_q, to_q;
    logic [DATA_W-1:0] data_q;
    logic              accept, bus_step, ack_ok, ack_bad, busy_bit;

    assign req_ready  = (step_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign bus_step   = (step_q == ST_DIRECT) || (step_q == ST_POLL) ||
                        (step_q == ST_WDATA)  || (step_q == ST_WCMD) ||
                        (step_q == ST_RDATA);
    assign ack_ok     = bus_step && bus_ack && !bus_err;
    assign ack_bad    = bus_step && bus_ack && bus_err;
    assign busy_bit   = bus_rdata[BUSY_BIT];
    assign poll_busy  = ack_ok && (step_q == ST_POLL) && busy_bit;
    assign poll_clear = accept || (ack_ok && (step_q == ST_WCMD));
    assign gap_run    = (step_q == ST_GAP);
    assign step       = step_q;
    assign rsp_valid  = (step_q == ST_RESP);
    assign rsp_rdata  = data_q;
    assign rsp_timeout = to_q;
    assign rsp_error  = err_q;

    // Next-step selection for the transaction chain
    always_comb begin
        step_d = step_q;
        unique case (step_q)
            ST_IDLE:
                if (accept) step_d = (cfg_chip_addr == '0) ? ST_DIRECT : ST_POLL;
            ST_DIRECT:
                if (bus_ack) step_d = ST_RESP;
            ST_POLL:
                if (bus_ack) begin
                    if (bus_err)
                        step_d = ST_RESP;
                    else if (busy_bit)
                        step_d = at_limit ? ST_RESP : ST_GAP;
                    else if (phase2_q)
                        step_d = l_write ? ST_RESP : ST_RDATA;
                    else
                        step_d = l_write ? ST_WDATA : ST_WCMD;
                end
            ST_GAP:
                if (gap_done) step_d = ST_POLL;
            ST_WDATA:
                if (bus_ack) step_d = bus_err ? ST_RESP : ST_WCMD;
            ST_WCMD:
                if (bus_ack) step_d = bus_err ? ST_RESP : ST_POLL;
            ST_RDATA:
                if (bus_ack) step_d = ST_RESP;
            ST_RESP:
                step_d = ST_IDLE;
            default:
                step_d = ST_IDLE;
        endcase
    end

    // Step register
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= ST_IDLE;
        else        step_q <= step_d;
    end

    // Latch the request and the addressing mode on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_write <= 1'b0;
            l_dev   <= '0;
            l_reg   <= '0;
            l_wdata <= '0;
            l_chip  <= '0;
        end else if (accept) begin
            l_write <= req_write;
            l_dev   <= req_dev;
            l_reg   <= req_reg;
            l_wdata <= req_wdata;
            l_chip  <= cfg_chip_addr;
        end
    end

    // Track which wait phase the engine is in
    always_ff @(posedge clk) begin
        if (!rst_n)                             phase2_q <= 1'b0;
        else if (accept)                        phase2_q <= 1'b0;
        else if (ack_ok && step_q == ST_WCMD)   phase2_q <= 1'b1;
    end

    // Collect response data and outcome flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            err_q  <= 1'b0;
            to_q   <= 1'b0;
        end else if (accept) begin
            data_q <= '0;
            err_q  <= 1'b0;
            to_q   <= 1'b0;
        end else begin
            if (ack_bad)
                err_q <= 1'b1;
            if (poll_busy && at_limit)
                to_q <= 1'b1;
            if (ack_ok && ((step_q == ST_RDATA) ||
                           (step_q == ST_DIRECT && !l_write)))
                data_q <= bus_rdata;
        end
    end

    a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_error && rsp_timeout));

    a_r10_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    a_r7_error_ends_chain: assert property (@(posedge clk) disable iff (!rst_n)
        ack_bad |=> rsp_valid);

endmodule

// File: rtl/mgmt_indirect_access.sv
// Indirect management register access engine, top level.
// Connects the sequencer, the poll timer and the lower-port decoder.
// Assumes the lower port answers each request with one bus_ack cycle
// and that cfg_chip_addr is stable while a request is accepted.
module mgmt_indirect_access
    import mgmt_acc_pkg::*;
#(
    parameter int POLL_GAP  = 1000,
    parameter int MAX_POLLS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_chip_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_dev,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_timeout,
    output logic              rsp_error,
    output logic              bus_req_valid,
    output logic              bus_req_write,
    output logic [ADDR_W-1:0] bus_req_phy,
    output logic [ADDR_W-1:0] bus_req_reg,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err
);
    step_t             step;
    logic              poll_clear, poll_busy, gap_run, gap_done, at_limit;
    logic              l_write;
    logic [ADDR_W-1:0] l_dev, l_reg, l_chip;
    logic [DATA_W-1:0] l_wdata;

    mgmt_acc_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_chip_addr (cfg_chip_addr),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_write     (req_write),
        .req_dev       (req_dev),
        .req_reg       (req_reg),
        .req_wdata     (req_wdata),
        .bus_ack       (bus_ack),
        .bus_err       (bus_err),
        .bus_rdata     (bus_rdata),
        .gap_done      (gap_done),
        .at_limit      (at_limit),
        .poll_clear    (poll_clear),
        .poll_busy     (poll_busy),
        .gap_run       (gap_run),
        .step          (step),
        .l_write       (l_write),
        .l_dev         (l_dev),
        .l_reg         (l_reg),
        .l_wdata       (l_wdata),
        .l_chip        (l_chip),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rsp_timeout   (rsp_timeout),
        .rsp_error     (rsp_error)
    );

    mgmt_poll_timer #(
        .POLL_GAP  (POLL_GAP),
        .MAX_POLLS (MAX_POLLS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (poll_clear),
        .busy_seen (poll_busy),
        .gap_run   (gap_run),
        .gap_done  (gap_done),
        .at_limit  (at_limit)
    );

    mgmt_bus_drive u_drive (
        .step          (step),
        .l_write       (l_write),
        .l_dev         (l_dev),
        .l_reg         (l_reg),
        .l_wdata       (l_wdata),
        .l_chip        (l_chip),
        .bus_req_valid (bus_req_valid),
        .bus_req_write (bus_req_write),
        .bus_req_phy   (bus_req_phy),
        .bus_req_reg   (bus_req_reg),
        .bus_req_wdata (bus_req_wdata)
    );

    a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_ack) |=> (bus_req_valid &&
            $stable({bus_req_write, bus_req_phy, bus_req_reg, bus_req_wdata})));

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> !req_ready);

endmodule

// File: tb/mgmt_indirect_access_test.sv
// Self-checking bench: behavioural switch model plus a transaction-list
// reference model, compared on every falling clock edge.
module mgmt_indirect_access_test;

    localparam int GAP  = 3;
    localparam int MAXP = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_chip_addr = 5'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_dev = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        rsp_timeout, rsp_error;
    logic        bus_req_valid, bus_req_write;
    logic [4:0]  bus_req_phy, bus_req_reg;
    logic [15:0] bus_req_wdata;
    logic        bus_ack = 1'b0;
    logic [15:0] bus_rdata = 16'hFFFF;
    logic        bus_err = 1'b0;

    always #2.5 clk = ~clk;

    mgmt_indirect_access #(.POLL_GAP(GAP), .MAX_POLLS(MAXP)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_chip_addr(cfg_chip_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_timeout(rsp_timeout), .rsp_error(rsp_error),
        .bus_req_valid(bus_req_valid), .bus_req_write(bus_req_write),
        .bus_req_phy(bus_req_phy), .bus_req_reg(bus_req_reg),
        .bus_req_wdata(bus_req_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference and switch-model state
    logic [26:0] exp_q[$];
    logic [15:0] e_data;
    bit          e_err, e_to;
    string       cur_tag = "R12";
    int          busy_left[2];
    int          err_at = -1;
    int          ack_lat = 0;
    logic [15:0] rd_val = 16'h0;
    int          txn_idx = 0;
    int          cmd_seen = 0;
    int          wait_cnt = 0;
    logic [26:0] snap;
    bit          gap_watch = 1'b0;
    int          gap_cnt = 0;
    int          rsp_cnt = 0;
    bit          prev_rsp = 1'b0;
    bit          in_flight = 1'b0;
    int          m_idx;
    bit          m_stop;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] cmd_word(input bit wr, input logic [4:0] d,
                                             input logic [4:0] r);
        return 16'h9000 | (wr ? 16'h0400 : 16'h0800) | {6'd0, d, r};
    endfunction

    // Reference model: append one expected transaction
    task automatic m_add(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd);
        if (m_stop) return;
        exp_q.push_back({wr, phy, rg, wd});
        if (m_idx == err_at) begin
            m_stop = 1'b1;
            e_err  = 1'b1;
        end
        m_idx++;
    endtask

    // Reference model: one busy-wait phase with n busy answers
    task automatic m_poll(input logic [4:0] chip, input int n);
        for (int k = 0; k < MAXP; k++) begin
            m_add(1'b0, chip, 5'd0, 16'd0);
            if (m_stop) return;
            if (k >= n) return;
        end
        m_stop = 1'b1;
        e_to   = 1'b1;
    endtask

    // Reference model: full expected transaction list and response
    task automatic m_plan(input bit wr, input logic [4:0] d, input logic [4:0] r,
                          input logic [15:0] wd, input logic [4:0] chip,
                          input int ba, input int bb);
        exp_q.delete();
        m_idx = 0; m_stop = 1'b0; e_err = 1'b0; e_to = 1'b0; e_data = 16'd0;
        if (chip == 5'd0) begin
            m_add(wr, d, r, wd);
            if (!m_stop && !wr) e_data = rd_val;
        end else begin
            m_poll(chip, ba);
            if (wr) m_add(1'b1, chip, 5'd1, wd);
            m_add(1'b1, chip, 5'd0, cmd_word(wr, d, r));
            if (!m_stop) m_poll(chip, bb);
            if (!wr) begin
                m_add(1'b0, chip, 5'd1, 16'd0);
                if (!m_stop) e_data = rd_val;
            end
        end
    endtask

    // Acceptance tracking for the readiness check (R8)
    always @(posedge clk) begin
        if (!rst_n) in_flight <= 1'b0;
        else if (req_valid && req_ready) in_flight <= 1'b1;
        else if (rsp_valid) in_flight <= 1'b0;
    end

    // Switch model, lower-port responder and per-cycle comparison
    always @(negedge clk) begin
        logic [26:0] cur, e;
        bit          poll, busy;
        bus_ack   = 1'b0;
        bus_err   = 1'b0;
        bus_rdata = 16'hFFFF;
        if (rst_n) begin
            chk(req_ready == !in_flight, "R8", "req_ready", 32'(req_ready), 32'(!in_flight));
            if (gap_watch) begin
                if (!bus_req_valid) gap_cnt++;
                else begin
                    chk(gap_cnt == GAP, "R5", "poll gap", gap_cnt, GAP);
                    gap_watch = 1'b0;
                end
            end
            if (bus_req_valid) begin
                cur = {bus_req_write, bus_req_phy, bus_req_reg, bus_req_wdata};
                if (wait_cnt == 0) snap = cur;
                else chk(cur == snap, "R11", "held request", 32'(cur), 32'(snap));
                if (wait_cnt == ack_lat) begin
                    wait_cnt = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, cur_tag, "unexpected transaction", 32'(cur), 32'd0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(cur[26:16] == e[26:16], cur_tag, "txn addr/dir",
                            32'(cur[26:16]), 32'(e[26:16]));
                        if (e[26])
                            chk(cur[15:0] == e[15:0],
                                (cfg_chip_addr != 0 && e[20:16] == 5'd0) ? "R4" : cur_tag,
                                "txn wdata", 32'(cur[15:0]), 32'(e[15:0]));
                    end
                    poll = (cfg_chip_addr != 5'd0) && !bus_req_write && (bus_req_reg == 5'd0);
                    busy = 1'b0;
                    if (poll && busy_left[cmd_seen] > 0) begin
                        busy = 1'b1;
                        busy_left[cmd_seen]--;
                    end
                    if (cfg_chip_addr != 5'd0 && bus_req_write && bus_req_reg == 5'd0)
                        cmd_seen = 1;
                    bus_err = (txn_idx == err_at);
                    txn_idx++;
                    if (poll) bus_rdata = busy ? 16'h8123 : 16'h0123;
                    else if (!bus_req_write) bus_rdata = rd_val;
                    else bus_rdata = 16'hDEAD;
                    bus_ack = 1'b1;
                    if (poll && busy && !bus_err) begin
                        gap_watch = 1'b1;
                        gap_cnt   = 0;
                    end
                end else begin
                    wait_cnt++;
                end
            end
            if (rsp_valid) begin
                chk(!prev_rsp, "R9", "response pulse width", 32'(prev_rsp), 32'd0);
                chk(rsp_rdata == e_data, cur_tag, "rsp_rdata", 32'(rsp_rdata), 32'(e_data));
                chk(rsp_timeout == e_to, cur_tag, "rsp_timeout", 32'(rsp_timeout), 32'(e_to));
                chk(rsp_error == e_err, cur_tag, "rsp_error", 32'(rsp_error), 32'(e_err));
                chk(exp_q.size() == 0, cur_tag, "missing transactions",
                    32'(exp_q.size()), 32'd0);
                gap_watch = 1'b0;
                rsp_cnt++;
            end
            prev_rsp = rsp_valid;
        end
    end

    // Issue one request and wait for its response
    task automatic do_req(input string tag, input logic [4:0] chip, input bit wr,
                          input logic [4:0] d, input logic [4:0] r,
                          input logic [15:0] wd, input int ba, input int bb,
                          input int ea, input int lat, input logic [15:0] rv);
        int start;
        @(negedge clk);
        cur_tag = tag;
        cfg_chip_addr = chip;
        busy_left[0] = ba;
        busy_left[1] = bb;
        err_at = ea;
        ack_lat = lat;
        rd_val = rv;
        txn_idx = 0;
        cmd_seen = 0;
        m_plan(wr, d, r, wd, chip, ba, bb);
        req_write = wr; req_dev = d; req_reg = r; req_wdata = wd;
        req_valid = 1'b1;
        start = rsp_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = 16'h5A5A;
        while (rsp_cnt == start) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R12", "ready after reset", 32'(req_ready), 32'd1);
        chk(bus_req_valid == 1'b0, "R12", "bus idle after reset", 32'(bus_req_valid), 32'd0);
        chk(rsp_valid == 1'b0, "R12", "no response after reset", 32'(rsp_valid), 32'd0);

        // Direct access
        do_req("R1", 5'd0, 1'b0, 5'd3, 5'd2, 16'h0000, 0, 0, -1, 0, 16'hBEEF);
        do_req("R1", 5'd0, 1'b1, 5'd17, 5'd4, 16'h1357, 0, 0, -1, 2, 16'h0000);
        // Indirect reads and writes with and without busy waits
        do_req("R2", 5'd9, 1'b0, 5'd27, 5'd26, 16'h0, 0, 0, -1, 0, 16'hA55A);
        do_req("R2", 5'd9, 1'b0, 5'd16, 5'd1, 16'h0, 2, 3, -1, 1, 16'h0F0F);
        do_req("R3", 5'd1, 1'b1, 5'd28, 5'd25, 16'hC0DE, 1, 0, -1, 0, 16'h0);
        do_req("R3", 5'd31, 1'b1, 5'd5, 5'd31, 16'h8001, 0, 4, -1, 2, 16'h0);
        // Attempt limit: last allowed poll clear, then all polls busy
        do_req("R6", 5'd2, 1'b0, 5'd4, 5'd6, 16'h0, MAXP - 1, 0, -1, 0, 16'h7E57);
        do_req("R6", 5'd2, 1'b0, 5'd4, 5'd6, 16'h0, MAXP, 0, -1, 0, 16'h7E57);
        do_req("R10", 5'd2, 1'b1, 5'd7, 5'd8, 16'h2468, 0, 0, -1, 0, 16'h0);
        do_req("R6", 5'd3, 1'b1, 5'd7, 5'd8, 16'h2468, 0, MAXP, -1, 0, 16'h0);
        // Lower-port errors at several points
        do_req("R7", 5'd4, 1'b0, 5'd1, 5'd1, 16'h0, 0, 0, 0, 0, 16'h1111);
        do_req("R7", 5'd4, 1'b0, 5'd1, 5'd1, 16'h0, 3, 0, 1, 1, 16'h1111);
        do_req("R7", 5'd4, 1'b1, 5'd1, 5'd1, 16'h4321, 0, 0, 2, 0, 16'h0);
        do_req("R7", 5'd4, 1'b0, 5'd1, 5'd1, 16'h0, 0, 0, 3, 0, 16'h2222);
        do_req("R7", 5'd0, 1'b0, 5'd6, 5'd9, 16'h0, 0, 0, 0, 0, 16'h3333);
        do_req("R10", 5'd4, 1'b0, 5'd2, 5'd3, 16'h0, 1, 1, -1, 0, 16'h6789);

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule